// File: doc/BRIEF.md
# I2C Master Start Generator with Collision Detect

This block produces the Start condition for an I2C master: with the clock line high, it pulls the data line low, then pulls the clock line low. It also watches the bus so that it does not fight another master. A one-cycle launch request starts it. Both bus lines come in through a two-flop synchronizer. The block drives them open-drain through pull-low enables, where an enable of 1 pulls the line low.

Each timing phase lasts `eff + 1` system clocks. Here `eff` is the 7-bit reload value, with a reload of zero raised to one. In the first phase both lines are released. In the second phase the data line is pulled. At the end of the second phase the block pulls the clock line, pulses a done strobe, and holds both lines low until the next stage signals that it has taken over.

The block gives up and sets a sticky collision flag in two cases:
- a line is already low at launch;
- the clock line is pulled low by someone else during the first phase.

A data line pulled low by another master during the first phase is not a collision. The block simply moves straight to the second phase. A Start-seen bit and an interrupt flag record any bus state with the data line low and the clock line high, and software clears all flags through one clear input.

Top module: `i2c_start_gen`

## Requirements
- R1: After reset, both pull enables, startBusy, startDone, startSeen, irqFlag and collFlag are 0.
- R2: If either synchronized line is low at the clock edge that takes startGo, collFlag is set at that same edge. No line is pulled and startBusy stays 0.
- R3: With both lines high, SDA is first pulled eff+1 clocks after the launch edge. In cycle count, sdaPullEn is first seen high in the (eff+2)-th cycle, counting the launch edge as cycle 1. eff is reloadVal, or 1 when reloadVal is 0.
- R4: SCL is pulled exactly eff+1 clocks after SDA is pulled. startDone is high for exactly that first cycle, and both pulls then stay high.
- R5: A reloadVal of 0 gives the same phase lengths as a reloadVal of 1.
- R6: If the synchronized SCL is low while the synchronized SDA is high during the first phase, the next edge sets collFlag. That same edge releases both lines and clears startBusy.
- R7: If the synchronized SDA is low during the first phase, the next edge pulls SDA and reloads the phase counter. The second phase then lasts eff+1 clocks, and collFlag stays 0.
- R8: SCL pulled low by another device during the second phase raises no collision. The Start still completes on time.
- R9: startSeen and irqFlag are set by any cycle in which the synchronized SDA is low and the synchronized SCL is high. irqFlag is also set by startDone. Both stay set until they are cleared.
- R10: flagClr clears startSeen, irqFlag and collFlag. When a set condition occurs in the same cycle as flagClr, the set wins.
- R11: nextOwn in the final holding state releases both lines and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startGo | input | 1 | One-cycle launch request, taken in idle |
| nextOwn | input | 1 | Next stage has taken the bus; leave the hold state |
| flagClr | input | 1 | Clears startSeen, irqFlag and collFlag |
| reloadVal | input | 7 | Phase length reload value |
| sdaIn | input | 1 | Raw SDA line level |
| sclIn | input | 1 | Raw SCL line level |
| sdaPullEn | output | 1 | 1 pulls SDA low |
| sclPullEn | output | 1 | 1 pulls SCL low |
| startBusy | output | 1 | Start sequence in progress (either phase) |
| startDone | output | 1 | One-cycle pulse when the Start completes |
| startSeen | output | 1 | Sticky: SDA low while SCL high was observed |
| irqFlag | output | 1 | Sticky interrupt flag |
| collFlag | output | 1 | Sticky bus-collision flag |

## Verification
The bench models the wired-AND bus, so the block's own pulls are fed back through the synchronizer. Every reload value from 0 to 127 is launched on a quiet bus, and each phase length is checked against eff+1, which separates correct counting from off-by-one and from mishandling of a zero reload.

Other masters are then injected at fixed cycles:
- a line already low at launch (SDA or SCL, which tells apart the cases that should also report a seen Start);
- SCL pulled low during the first phase (a collision);
- SDA pulled low during the first phase (an early pull that is not a collision);
- SCL pulled low during the second phase (no effect).

Flag clearing is tried both with the set condition still present and after it is gone.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_SDALO = 2'd2,
    ST_HELD  = 2'd3
  } start_state_e;

  typedef struct packed {
    logic cntLoad;
    logic cntDec;
    logic collSet;
    logic doneSet;
  } start_strobe_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '1;
          else       stageQ[s] <= rawIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '1;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/i2c_start_dp.sv
module i2c_start_dp
  import i2c_start_pkg::*;
#(
  parameter int RELOAD_W    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sdaIn,
  input  logic                sclIn,
  input  logic [RELOAD_W-1:0] reloadVal,
  input  logic                flagClr,
  input  start_strobe_t       strobe,
  output logic                sdaS,
  output logic                sclS,
  output logic                cntZero,
  output logic                startDone,
  output logic                startSeen,
  output logic                irqFlag,
  output logic                collFlag
);

  localparam int LINES = 2;
  localparam logic [RELOAD_W-1:0] ONE_COUNT = RELOAD_W'(1);

  logic [LINES-1:0]    lineSync;
  logic [RELOAD_W-1:0] cntQ;
  logic [RELOAD_W-1:0] effReload;
  logic                busStartSeen;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .rawIn  ({sclIn, sdaIn}),
    .syncOut(lineSync)
  );

  assign sdaS = lineSync[0];
  assign sclS = lineSync[1];

  // a zero reload behaves as one count
  assign effReload = (reloadVal == '0) ? ONE_COUNT : reloadVal;
  assign cntZero   = (cntQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cntQ <= '0;
    else if (strobe.cntLoad) cntQ <= effReload;
    else if (strobe.cntDec && !cntZero) cntQ <= cntQ - ONE_COUNT;
  end

  assign busStartSeen = !sdaS && sclS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startDone <= 1'b0;
      startSeen <= 1'b0;
      irqFlag   <= 1'b0;
      collFlag  <= 1'b0;
    end else begin
      startDone <= strobe.doneSet;
      if (busStartSeen)                       startSeen <= 1'b1;
      else if (flagClr)                       startSeen <= 1'b0;
      if (busStartSeen || strobe.doneSet)     irqFlag   <= 1'b1;
      else if (flagClr)                       irqFlag   <= 1'b0;
      if (strobe.collSet)                     collFlag  <= 1'b1;
      else if (flagClr)                       collFlag  <= 1'b0;
    end
  end

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntLoad |=> !cntZero); // R5

  AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (collFlag && !flagClr) |=> collFlag); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    startDone |=> !startDone); // R4

  AST_SEEN_SETS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    busStartSeen |=> (startSeen && irqFlag)); // R9

endmodule

// File: rtl/i2c_start_ctrl.sv
module i2c_start_ctrl
  import i2c_start_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          startGo,
  input  logic          nextOwn,
  input  logic          sdaS,
  input  logic          sclS,
  input  logic          cntZero,
  output start_strobe_t strobe,
  output logic          sdaPullEn,
  output logic          sclPullEn,
  output logic          startBusy
);

  start_state_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startGo) begin
          if (!sdaS || !sclS) begin
            strobe.collSet = 1'b1;
          end else begin
            strobe.cntLoad = 1'b1;
            stateD         = ST_SETUP;
          end
        end
      end
      ST_SETUP: begin
        if (sdaS && !sclS) begin
          strobe.collSet = 1'b1;
          stateD         = ST_IDLE;
        end else if (!sdaS || cntZero) begin
          strobe.cntLoad = 1'b1;
          stateD         = ST_SDALO;
        end else begin
          strobe.cntDec = 1'b1;
        end
      end
      ST_SDALO: begin
        if (cntZero) begin
          strobe.doneSet = 1'b1;
          stateD         = ST_HELD;
        end else begin
          strobe.cntDec = 1'b1;
        end
      end
      ST_HELD: begin
        if (nextOwn) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign sdaPullEn = (stateQ == ST_SDALO) || (stateQ == ST_HELD);
  assign sclPullEn = (stateQ == ST_HELD);
  assign startBusy = (stateQ == ST_SETUP) || (stateQ == ST_SDALO);

  AST_SCL_AFTER_SDA: assert property (@(posedge clk) disable iff (!rstN)
    sclPullEn |-> sdaPullEn); // R4

  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.collSet |=> (!sdaPullEn && !sclPullEn && !startBusy)); // R6

  AST_EARLY_SDA: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SETUP && !sdaS) |=> sdaPullEn); // R7

  AST_PHASE2_NO_COLL: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SDALO) |-> !strobe.collSet); // R8

  AST_HANDOFF: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HELD && nextOwn) |=> (!sdaPullEn && !sclPullEn)); // R11

endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
  import i2c_start_pkg::*;
#(
  parameter int RELOAD_W    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startGo,
  input  logic                nextOwn,
  input  logic                flagClr,
  input  logic [RELOAD_W-1:0] reloadVal,
  input  logic                sdaIn,
  input  logic                sclIn,
  output logic                sdaPullEn,
  output logic                sclPullEn,
  output logic                startBusy,
  output logic                startDone,
  output logic                startSeen,
  output logic                irqFlag,
  output logic                collFlag
);

  start_strobe_t strobe;
  logic sdaS, sclS, cntZero;

  i2c_start_dp #(.RELOAD_W(RELOAD_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sdaIn    (sdaIn),
    .sclIn    (sclIn),
    .reloadVal(reloadVal),
    .flagClr  (flagClr),
    .strobe   (strobe),
    .sdaS     (sdaS),
    .sclS     (sclS),
    .cntZero  (cntZero),
    .startDone(startDone),
    .startSeen(startSeen),
    .irqFlag  (irqFlag),
    .collFlag (collFlag)
  );

  i2c_start_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startGo  (startGo),
    .nextOwn  (nextOwn),
    .sdaS     (sdaS),
    .sclS     (sclS),
    .cntZero  (cntZero),
    .strobe   (strobe),
    .sdaPullEn(sdaPullEn),
    .sclPullEn(sclPullEn),
    .startBusy(startBusy)
  );

endmodule

// File: tb/i2c_start_gen_bench.sv
`timescale 1ns/1ps
module i2c_start_gen_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startGo = 1'b0, nextOwn = 1'b0, flagClr = 1'b0;
  logic [6:0] reloadVal = '0;
  logic extSdaLow = 1'b0, extSclLow = 1'b0;
  logic sdaIn, sclIn;
  logic sdaPullEn, sclPullEn, startBusy, startDone, startSeen, irqFlag, collFlag;

  int nTests = 0;
  int nFail  = 0;
  int n      = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // wired-AND bus: released lines read high
  assign sdaIn = !(sdaPullEn || extSdaLow);
  assign sclIn = !(sclPullEn || extSclLow);

  i2c_start_gen u_i2c_start_gen (
    .clk(clk), .rstN(rstN), .startGo(startGo), .nextOwn(nextOwn), .flagClr(flagClr),
    .reloadVal(reloadVal), .sdaIn(sdaIn), .sclIn(sclIn),
    .sdaPullEn(sdaPullEn), .sclPullEn(sclPullEn), .startBusy(startBusy),
    .startDone(startDone), .startSeen(startSeen), .irqFlag(irqFlag), .collFlag(collFlag)
  );

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    n++;
  endtask

  task automatic launch();
    n = 0;
    startGo = 1'b1;
    tick();
    startGo = 1'b0;
  endtask

  task automatic settle();
    repeat (4) tick();
  endtask

  task automatic clearFlags();
    flagClr = 1'b1;
    tick();
    flagClr = 1'b0;
  endtask

  task automatic handOff();
    nextOwn = 1'b1;
    tick();
    nextOwn = 1'b0;
    extSdaLow = 1'b0;
    extSclLow = 1'b0;
    settle();
    clearFlags();
  endtask

  function automatic int effOf(input int r);
    return (r == 0) ? 1 : r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int m;
    int eff;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sdaPullEn", int'(sdaPullEn), 0);
    check("R1 sclPullEn", int'(sclPullEn), 0);
    check("R1 flags", int'({startBusy, startDone, startSeen, irqFlag, collFlag}), 0);
    rstN = 1'b1;
    settle();

    // R3 R4 R5 R9: sweep every reload value on a quiet bus
    for (int r = 0; r < 128; r++) begin
      reloadVal = 7'(r);
      eff = effOf(r);
      launch();
      check("R3 busy after launch", int'(startBusy), 1);
      while (!sdaPullEn && n < 600) tick();
      check((r == 0) ? "R5 phase1 length" : "R3 phase1 length", n, eff + 2);
      m = n;
      while (!sclPullEn && n < 600) tick();
      check((r == 0) ? "R5 phase2 length" : "R4 phase2 length", n - m, eff + 1);
      check("R4 done pulse high", int'(startDone), 1);
      tick();
      check("R4 done pulse ends", int'(startDone), 0);
      check("R4 both held", int'({sdaPullEn, sclPullEn}), 3);
      check("R9 irq and seen after own start", int'({irqFlag, startSeen}), 3);
      check("R8 no collision on clean start", int'(collFlag), 0);
      nextOwn = 1'b1;
      tick();
      nextOwn = 1'b0;
      check("R11 released after handoff", int'({sdaPullEn, sclPullEn, startBusy}), 0);
      settle();
      clearFlags();
    end

    // R10 flags cleared
    check("R10 cleared", int'({startSeen, irqFlag, collFlag}), 0);

    // R2 SDA low at launch
    reloadVal = 7'd20;
    extSdaLow = 1'b1;
    settle();
    launch();
    check("R2 sda-low abort coll", int'(collFlag), 1);
    check("R2 sda-low abort idle", int'({startBusy, sdaPullEn, sclPullEn}), 0);
    check("R9 seen from foreign sda low", int'({startSeen, irqFlag}), 3);
    // R10 set wins over clear while SDA still low
    clearFlags();
    check("R10 set wins", int'({startSeen, irqFlag}), 3);
    check("R10 coll cleared", int'(collFlag), 0);
    extSdaLow = 1'b0;
    settle();
    clearFlags();
    check("R10 clear after release", int'({startSeen, irqFlag, collFlag}), 0);

    // R2 SCL low at launch
    extSclLow = 1'b1;
    settle();
    launch();
    check("R2 scl-low abort coll", int'(collFlag), 1);
    check("R2 scl-low abort seen", int'(startSeen), 0);
    repeat (3) tick();
    check("R2 scl-low stays idle", int'({startBusy, sdaPullEn, sclPullEn}), 0);
    extSclLow = 1'b0;
    settle();
    clearFlags();

    // R6 SCL pulled low during phase 1
    launch();
    repeat (4) tick();
    extSclLow = 1'b1;
    tick(); tick();
    check("R6 not yet flagged", int'(collFlag), 0);
    tick();
    check("R6 coll at n=8", n * 10 + int'(collFlag), 81);
    check("R6 aborted", int'({startBusy, sdaPullEn, sclPullEn}), 0);
    extSclLow = 1'b0;
    settle();
    clearFlags();

    // R7 SDA pulled low by another master during phase 1
    launch();
    repeat (4) tick();
    extSdaLow = 1'b1;
    while (!sdaPullEn && n < 600) tick();
    check("R7 early sda cycle", n, 8);
    while (!sclPullEn && n < 600) tick();
    check("R7 phase2 after reload", n, 8 + 21);
    check("R7 no collision", int'(collFlag), 0);
    check("R9 foreign start seen", int'(startSeen), 1);
    handOff();

    // R8 SCL pulled low during phase 2
    launch();
    while (!sdaPullEn && n < 600) tick();
    check("R8 phase1 normal", n, 22);
    tick(); tick();
    extSclLow = 1'b1;
    while (!sclPullEn && n < 600) tick();
    check("R8 completes on time", n, 22 + 21);
    check("R8 no collision", int'(collFlag), 0);
    check("R8 done pulse", int'(startDone), 1);
    handOff();
    check("R11 idle after handoff", int'({sdaPullEn, sclPullEn, startBusy}), 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule